// File: doc/BRIEF.md
# Real-Time Counter with Match Alarm and Wake Latch

This block keeps time in whole seconds. An external one-second tick pulse advances a 32-bit up counter and a 32-bit down counter together. Two compare registers watch the up counter. When the up counter steps onto a compare value, a sticky status flag is set. Each flag can be routed to the interrupt line.

A wake output is meant to power up the rest of a system. It goes high on an enabled compare event and then stays high. It reacts to compare events only after software has written a fixed unlock word into a key register. A control bit can force the output high at any time. Software clears the flags and the wake latch by writing ones to the status word. A software reset bit holds the counters and latches at zero for as long as it stays set.

All state is reached over a simple word-addressed register bus with a write strobe and combinational read data. The address space also holds a 32-word scratch memory for data that must survive while the rest of the system sleeps.

Top module: `rtc_wake_timer`

## Requirements
- R1: Word addresses decode as follows: 0 up counter, 1 down counter, 2 compare 0, 3 compare 1, 4 control, 5 status, 6 key, 32–63 scratch memory (read/write). Words 7–31 read as zero and ignore writes. Read data is a combinational function of `bus_addr_i`, and a write becomes visible after the clock edge that samples `bus_we_i`.
- R2: On a clock where `sec_tick_i` is 1, the halt bit (control bit 6) is 0 and the software reset bit (control bit 4) is 0, the up counter adds 1 and the down counter subtracts 1. Both wrap modulo 2^32.
- R3: While control bit 6 is 1, ticks change neither counter.
- R4: A compare event for compare k (k = 0, 1) occurs on a counting tick whose new up-counter value equals compare k. It sets status bit k whatever the enables are. Holding the counter on that value without further counting ticks does not set the flag again.
- R5: `irq_o` is 1 exactly when (status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1).
- R6: When the key register holds 0xB5C13F27, a compare 0 event with control bit 2 set, or a compare 1 event with control bit 3 set, sets the wake latch. The latch reads as status bit 2, drives `wake_o` high, and stays set through further ticks.
- R7: When the key register holds any other value, compare events never set the wake latch.
- R8: Control bit 7 drives `wake_o` high regardless of the latch. With bit 7 clear, `wake_o` equals the wake latch.
- R9: Writing status with bit n (n = 0, 1, 2) set clears that flag or the wake latch, and writing zeros changes nothing. If a compare event and its clear fall on the same clock, the flag stays set.
- R10: While control bit 4 is 1, both counters are held at zero (bus writes and ticks included), and the status flags and wake latch are cleared. The compare, key and scratch words keep their values. Bit 4 remains set until software writes it to 0.
- R11: After `rst_n` is asserted, every register and scratch word reads zero and `wake_o` and `irq_o` are low.
- R12: A bus write to a counter on the same clock as a counting tick loads the written value. The other counter still counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick_i | input | 1 | One-clock pulse once per second |
| bus_addr_i | input | 6 | Word address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Enabled compare flag pending |
| wake_o | output | 1 | Latched or forced wake request |

## Verification
The bench uses the default parameters: 32-bit data, a 6-bit word address, the scratch memory at word 32 with 32 words, and the 0xB5C13F27 unlock word. With these values the whole map fits the address bus, so reserved words, the scratch window and every register can be reached directly. Because the counters are writable, compare events and the wrap of the down counter from zero to all ones take only a few ticks to reach. The unlock comparison is exercised with both a wrong key (zero) and the correct key.

// File: rtl/rtc_wake_pkg.sv
package rtc_wake_pkg;

    // Number of compare channels; control and status bit layouts depend on it.
    localparam int NUM_MATCH = 2;

    // Word offsets of the register file. The order is fixed by the bus map.
    localparam int OFF_UP    = 0;
    localparam int OFF_DOWN  = 1;
    localparam int OFF_MATCH = 2;
    localparam int OFF_CTRL  = OFF_MATCH + NUM_MATCH;
    localparam int OFF_STAT  = OFF_CTRL + 1;
    localparam int OFF_KEY   = OFF_STAT + 1;

    // Control word, bit 7 down to bit 0.
    typedef struct packed {
        logic force_wake;   // 7
        logic halt;         // 6
        logic spare;        // 5, always zero
        logic soft_rst;     // 4
        logic wake_en1;     // 3
        logic wake_en0;     // 2
        logic irq_en1;      // 1
        logic irq_en0;      // 0
    } ctrl_t;

endpackage

// File: rtl/rtc_count_core.sv
module rtc_count_core
    import rtc_wake_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick_i,
    input  logic                          run_i,
    input  logic                          clear_i,
    input  logic                          wr_up_i,
    input  logic                          wr_down_i,
    input  logic [W-1:0]                  wr_data_i,
    input  logic [NUM_MATCH-1:0][W-1:0]   match_i,
    output logic [W-1:0]                  up_o,
    output logic [W-1:0]                  down_o,
    output logic [NUM_MATCH-1:0]          hit_o
);

    typedef struct packed {
        logic [W-1:0] up;
        logic [W-1:0] down;
    } cnt_t;

    cnt_t       cnt_d, cnt_q;
    logic       step;
    logic [W-1:0] up_inc;

    always_comb begin
        step   = tick_i && run_i && !clear_i;
        up_inc = cnt_q.up + W'(1);
        cnt_d  = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else begin
            if (wr_up_i)       cnt_d.up = wr_data_i;
            else if (step)     cnt_d.up = up_inc;
            if (wr_down_i)     cnt_d.down = wr_data_i;
            else if (step)     cnt_d.down = cnt_q.down - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // One comparator per channel, evaluated only on a counting step.
    for (genvar k = 0; k < NUM_MATCH; k++) begin : g_cmp
        assign hit_o[k] = step && !wr_up_i && (up_inc == match_i[k]);
    end

    assign up_o   = cnt_q.up;
    assign down_o = cnt_q.down;

    assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && !clear_i && !wr_up_i) |=> (cnt_q.up == $past(cnt_q.up) + W'(1)));

    assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clear_i && !wr_up_i && !wr_down_i) |=> ($stable(cnt_q.up) && $stable(cnt_q.down)));

    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q.up == '0 && cnt_q.down == '0));

    assert_load_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_up_i && !clear_i) |=> (cnt_q.up == $past(wr_data_i)));

endmodule

// File: rtl/rtc_event_latch.sv
module rtc_event_latch
    import rtc_wake_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic [NUM_MATCH-1:0]  hit_i,
    input  logic [NUM_MATCH-1:0]  irq_en_i,
    input  logic [NUM_MATCH-1:0]  wake_en_i,
    input  logic                  key_ok_i,
    input  logic                  force_i,
    input  logic                  clr_we_i,
    input  logic [NUM_MATCH:0]    clr_mask_i,
    output logic [NUM_MATCH:0]    status_o,
    output logic                  irq_o,
    output logic                  wake_o
);

    typedef struct packed {
        logic                 wake;
        logic [NUM_MATCH-1:0] flag;
    } evt_t;

    evt_t evt_d, evt_q;
    evt_t clr;

    always_comb begin
        clr   = clr_we_i ? evt_t'(clr_mask_i) : '0;
        evt_d = evt_q;
        if (clear_i) begin
            evt_d = '0;
        end else begin
            // A new event outranks a clear in the same cycle.
            evt_d.flag = (evt_q.flag & ~clr.flag) | hit_i;
            evt_d.wake = (evt_q.wake & ~clr.wake) | (key_ok_i && |(hit_i & wake_en_i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    assign status_o = evt_q;
    assign irq_o    = |(evt_q.flag & irq_en_i);
    assign wake_o   = evt_q.wake | force_i;

    assert_wake_keyed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !key_ok_i |=> (!evt_q.wake || $past(evt_q.wake)));

    assert_wake_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q.wake && !clear_i && !(clr_we_i && clr_mask_i[NUM_MATCH])) |=> evt_q.wake);

    assert_flag_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && clr_mask_i[0] && !hit_i[0] && !clear_i) |=> !evt_q.flag[0]);

    assert_latch_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (status_o == '0));

endmodule

// File: rtl/rtc_scratch_mem.sv
module rtc_scratch_mem #(
    parameter int W     = 32,
    parameter int WORDS = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [IW-1:0] idx_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o
);

    logic [W-1:0] mem_d [WORDS];
    logic [W-1:0] mem_q [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) mem_d[i] = mem_q[i];
        if (we_i) mem_d[idx_i] = wdata_i;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rdata_o = mem_q[idx_i];

    assert_mem_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(idx_i)] == $past(wdata_i)));

endmodule

// File: rtl/rtc_wake_timer.sv
module rtc_wake_timer
    import rtc_wake_pkg::*;
#(
    parameter int          DATA_W        = 32,
    parameter int          ADDR_W        = 6,
    parameter int          SCRATCH_BASE  = 32,
    parameter int          SCRATCH_WORDS = 32,
    parameter logic [31:0] UNLOCK_KEY    = 32'hB5C1_3F27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              wake_o
);

    localparam int SIDX_W  = $clog2(SCRATCH_WORDS);
    localparam int SCR_END = SCRATCH_BASE + SCRATCH_WORDS;

    typedef struct packed {
        logic [NUM_MATCH-1:0][DATA_W-1:0] match;
        ctrl_t                            ctrl;
        logic [DATA_W-1:0]                key;
    } regs_t;

    regs_t regs_d, regs_q;

    int                    aidx;
    logic                  in_scr;
    logic [SIDX_W-1:0]     sidx;
    logic                  we_up, we_down, we_stat, we_scr;
    logic [DATA_W-1:0]     up_w, down_w, scr_rdata;
    logic [NUM_MATCH-1:0]  hit_w;
    logic [NUM_MATCH:0]    status_w;
    logic                  key_ok;

    // Address decode.
    always_comb begin
        aidx    = int'(bus_addr_i);
        in_scr  = (aidx >= SCRATCH_BASE) && (aidx < SCR_END);
        sidx    = SIDX_W'(aidx - SCRATCH_BASE);
        we_up   = bus_we_i && (aidx == OFF_UP);
        we_down = bus_we_i && (aidx == OFF_DOWN);
        we_stat = bus_we_i && (aidx == OFF_STAT);
        we_scr  = bus_we_i && in_scr;
    end

    // Next-state of the configuration registers.
    always_comb begin
        regs_d = regs_q;
        if (bus_we_i) begin
            for (int k = 0; k < NUM_MATCH; k++) begin
                if (aidx == OFF_MATCH + k) regs_d.match[k] = bus_wdata_i;
            end
            if (aidx == OFF_CTRL) begin
                regs_d.ctrl       = ctrl_t'(bus_wdata_i[7:0]);
                regs_d.ctrl.spare = 1'b0;
            end
            if (aidx == OFF_KEY) regs_d.key = bus_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign key_ok = (regs_q.key == DATA_W'(UNLOCK_KEY));

    rtc_count_core #(.W(DATA_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (sec_tick_i),
        .run_i     (!regs_q.ctrl.halt),
        .clear_i   (regs_q.ctrl.soft_rst),
        .wr_up_i   (we_up),
        .wr_down_i (we_down),
        .wr_data_i (bus_wdata_i),
        .match_i   (regs_q.match),
        .up_o      (up_w),
        .down_o    (down_w),
        .hit_o     (hit_w)
    );

    rtc_event_latch u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (regs_q.ctrl.soft_rst),
        .hit_i      (hit_w),
        .irq_en_i   ({regs_q.ctrl.irq_en1, regs_q.ctrl.irq_en0}),
        .wake_en_i  ({regs_q.ctrl.wake_en1, regs_q.ctrl.wake_en0}),
        .key_ok_i   (key_ok),
        .force_i    (regs_q.ctrl.force_wake),
        .clr_we_i   (we_stat),
        .clr_mask_i (bus_wdata_i[NUM_MATCH:0]),
        .status_o   (status_w),
        .irq_o      (irq_o),
        .wake_o     (wake_o)
    );

    rtc_scratch_mem #(.W(DATA_W), .WORDS(SCRATCH_WORDS)) u_scratch (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we_scr),
        .idx_i   (sidx),
        .wdata_i (bus_wdata_i),
        .rdata_o (scr_rdata)
    );

    // Read multiplexer; unmapped words return zero.
    always_comb begin
        bus_rdata_o = '0;
        if (aidx == OFF_UP)   bus_rdata_o = up_w;
        if (aidx == OFF_DOWN) bus_rdata_o = down_w;
        for (int k = 0; k < NUM_MATCH; k++) begin
            if (aidx == OFF_MATCH + k) bus_rdata_o = regs_q.match[k];
        end
        if (aidx == OFF_CTRL) bus_rdata_o = DATA_W'(regs_q.ctrl);
        if (aidx == OFF_STAT) bus_rdata_o = DATA_W'(status_w);
        if (aidx == OFF_KEY)  bus_rdata_o = regs_q.key;
        if (in_scr)           bus_rdata_o = scr_rdata;
    end

    assert_srst_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.ctrl.soft_rst |=> !irq_o);

    assert_srst_persist_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ctrl.soft_rst && !(bus_we_i && aidx == OFF_CTRL)) |=> regs_q.ctrl.soft_rst);

endmodule

// File: tb/rtc_wake_timer_tb.sv
module rtc_wake_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick_i = 1'b0;
    logic [5:0]  bus_addr_i = '0;
    logic        bus_we_i = 1'b0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        irq_o;
    logic        wake_o;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    rtc_wake_timer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_tick_i  (sec_tick_i),
        .bus_addr_i  (bus_addr_i),
        .bus_we_i    (bus_we_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o),
        .wake_o      (wake_o)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;
    localparam int NV = 25;
    // {op, addr, data, expected}
    localparam logic [71:0] VEC [NV] = '{
        {OP_WR, 6'd0,  32'h0000_0010, 32'h0},
        {OP_RD, 6'd0,  32'h0,         32'h0000_0010},  // R1
        {OP_WR, 6'd1,  32'h0000_0100, 32'h0},
        {OP_TK, 6'd0,  32'h0,         32'h0},
        {OP_RD, 6'd0,  32'h0,         32'h0000_0011},  // R2
        {OP_RD, 6'd1,  32'h0,         32'h0000_00FF},  // R2
        {OP_WR, 6'd4,  32'h0000_0040, 32'h0},
        {OP_TK, 6'd0,  32'h0,         32'h0},
        {OP_RD, 6'd0,  32'h0,         32'h0000_0011},  // R3
        {OP_RD, 6'd1,  32'h0,         32'h0000_00FF},  // R3
        {OP_WR, 6'd4,  32'h0000_0000, 32'h0},
        {OP_WR, 6'd2,  32'h0000_0013, 32'h0},
        {OP_TK, 6'd0,  32'h0,         32'h0},
        {OP_RD, 6'd5,  32'h0,         32'h0},          // R4 no event yet
        {OP_TK, 6'd0,  32'h0,         32'h0},
        {OP_RD, 6'd5,  32'h0,         32'h0000_0001},  // R4
        {OP_WR, 6'd5,  32'h0000_0001, 32'h0},
        {OP_RD, 6'd5,  32'h0,         32'h0},          // R9
        {OP_RD, 6'd5,  32'h0,         32'h0},          // R4 no retrigger
        {OP_WR, 6'd7,  32'hFFFF_FFFF, 32'h0},
        {OP_RD, 6'd7,  32'h0,         32'h0},          // R1 reserved
        {OP_WR, 6'd3,  32'h0000_ABCD, 32'h0},
        {OP_RD, 6'd3,  32'h0,         32'h0000_ABCD},  // R1
        {OP_WR, 6'd40, 32'h0000_A5A5, 32'h0},
        {OP_RD, 6'd40, 32'h0,         32'h0000_A5A5}   // R1 scratch
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1; sec_tick_i = tk;
        @(negedge clk);
        bus_we_i = 1'b0; sec_tick_i = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick_i = 1'b1;
        @(negedge clk);
        sec_tick_i = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr_i = a;
        #1;
        check(req, bus_rdata_o, exp);
    endtask

    task automatic pin_chk(input string req, input logic act, input logic exp);
        @(negedge clk);
        #1;
        check(req, {31'b0, act}, {31'b0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd_chk("R11 up", 6'd0, 32'h0);
        rd_chk("R11 down", 6'd1, 32'h0);
        rd_chk("R11 ctrl", 6'd4, 32'h0);
        rd_chk("R11 status", 6'd5, 32'h0);
        rd_chk("R11 key", 6'd6, 32'h0);
        rd_chk("R11 scratch", 6'd40, 32'h0);
        pin_chk("R11 wake", wake_o, 1'b0);
        pin_chk("R11 irq", irq_o, 1'b0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][71:70])
                OP_WR:   bus_wr(VEC[i][69:64], VEC[i][63:32], 1'b0);
                OP_TK:   tick();
                default: rd_chk("R1-table", VEC[i][69:64], VEC[i][31:0]);
            endcase
        end

        // R12: load and tick in one cycle; down still counts
        bus_wr(6'd0, 32'h0000_0050, 1'b1);
        rd_chk("R12 up loaded", 6'd0, 32'h0000_0050);
        rd_chk("R12 down counted", 6'd1, 32'h0000_00FC);

        // R5 interrupt gating
        bus_wr(6'd2, 32'h0000_0051, 1'b0);
        tick();
        rd_chk("R4 flag0", 6'd5, 32'h1);
        pin_chk("R5 irq disabled", irq_o, 1'b0);
        bus_wr(6'd4, 32'h1, 1'b0);
        pin_chk("R5 irq enabled", irq_o, 1'b1);
        bus_wr(6'd4, 32'h2, 1'b0);
        pin_chk("R5 other enable", irq_o, 1'b0);
        bus_wr(6'd4, 32'h0, 1'b0);

        // R9 set wins over clear, zeros ignored
        bus_wr(6'd3, 32'h0000_0052, 1'b0);
        bus_wr(6'd5, 32'h2, 1'b1);
        rd_chk("R9 set wins", 6'd5, 32'h3);
        bus_wr(6'd5, 32'h0, 1'b0);
        rd_chk("R9 zero write", 6'd5, 32'h3);
        bus_wr(6'd5, 32'h3, 1'b0);
        rd_chk("R9 cleared", 6'd5, 32'h0);

        // R7 no key
        bus_wr(6'd4, 32'h4, 1'b0);
        bus_wr(6'd2, 32'h0000_0053, 1'b0);
        tick();
        rd_chk("R7 status", 6'd5, 32'h1);
        pin_chk("R7 wake", wake_o, 1'b0);

        // R6 with key
        bus_wr(6'd6, 32'hB5C1_3F27, 1'b0);
        rd_chk("R1 key", 6'd6, 32'hB5C1_3F27);
        bus_wr(6'd5, 32'h7, 1'b0);
        bus_wr(6'd2, 32'h0000_0054, 1'b0);
        tick();
        pin_chk("R6 wake set", wake_o, 1'b1);
        rd_chk("R6 status", 6'd5, 32'h5);
        tick();
        pin_chk("R6 wake held", wake_o, 1'b1);
        bus_wr(6'd5, 32'h4, 1'b0);
        pin_chk("R9 wake cleared", wake_o, 1'b0);
        rd_chk("R9 flag kept", 6'd5, 32'h1);

        // R8 force
        bus_wr(6'd4, 32'h84, 1'b0);
        pin_chk("R8 forced", wake_o, 1'b1);
        bus_wr(6'd4, 32'h04, 1'b0);
        pin_chk("R8 released", wake_o, 1'b0);

        // R10 software reset
        bus_wr(6'd2, 32'h0000_0056, 1'b0);
        tick();
        pin_chk("R6 wake again", wake_o, 1'b1);
        bus_wr(6'd4, 32'h10, 1'b0);
        tick();
        bus_wr(6'd0, 32'h0000_0099, 1'b0);
        rd_chk("R10 up", 6'd0, 32'h0);
        rd_chk("R10 down", 6'd1, 32'h0);
        rd_chk("R10 status", 6'd5, 32'h0);
        pin_chk("R10 wake", wake_o, 1'b0);
        rd_chk("R10 ctrl persists", 6'd4, 32'h10);
        rd_chk("R10 match kept", 6'd2, 32'h0000_0056);
        rd_chk("R10 key kept", 6'd6, 32'hB5C1_3F27);
        rd_chk("R10 scratch kept", 6'd40, 32'h0000_A5A5);
        bus_wr(6'd4, 32'h0, 1'b0);
        tick();
        rd_chk("R2 up after reset", 6'd0, 32'h1);
        rd_chk("R2 down wraps", 6'd1, 32'hFFFF_FFFF);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule